// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block turns a single PWM command into two gate-enable outputs for a half-bridge: one for the high-side switch and one for the low-side switch. The two outputs are never active together. When the command changes, the controller first drops the gate that is on. It then waits for a digital "gate is low" feedback from that gate. Only after that feedback arrives does it start a programmable dead-time count, and only when the count expires does it enable the other gate. Analog comparators and drive stages are outside the block. They appear here only as single-bit feedback inputs and as 8-bit supply codes.

Two undervoltage lockouts with separate trip and release thresholds act on the outputs. A main-supply lockout holds both gates off. A bootstrap-supply lockout holds only the high-side gate off, and the low side keeps following the command. A second safeguard covers feedback that never arrives: if the outgoing gate's feedback does not show low within a programmable number of cycles, a sticky fault turns both gates off until software clears it. The PWM input and both feedback inputs pass through synchronizer chains before they are used. The block runs from a single clock of nominally 100 MHz.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: `hs_en` and `ls_en` are never 1 in the same cycle.
- R2: On a rising PWM command, `ls_en` falls first. `hs_en` rises only after the low-side feedback reads low and the dead time D has then elapsed. When the feedback follows the gate with no delay, exactly 3 + D clock cycles pass with both outputs low between the fall of `ls_en` and the rise of `hs_en`.
- R3: On a falling PWM command, `hs_en` falls first. `ls_en` rises only after the high-side feedback reads low and D has then elapsed. With instant feedback, the gap is again 3 + D cycles.
- R4: D is `dead_cycles` clamped to the range 9 to 20. For example, 3 gives 9, 25 gives 20, and 12 gives 12.
- R5: While the main-supply lockout is active, both outputs are 0. The lockout is active from reset until `vdd_code` reaches `vdd_rel_th`.
- R6: While the bootstrap lockout is active, `hs_en` stays 0 and `ls_en` still follows a low PWM command.
- R7: Each lockout has hysteresis. An active lockout releases when the code is at least the release threshold. An inactive lockout engages when the code is below the trip threshold. A code between the two thresholds keeps the current state.
- R8: If the PWM command reverses while a dead-time wait is pending, that wait is abandoned and the gate it was leading to never turns on. The opposite sequence then runs, and it still checks feedback.
- R9: If the outgoing gate's feedback stays high for `fb_timeout` cycles (0 is treated as 1) while a new gate is requested, `fault` is set. The fault holds both outputs at 0 until `fault_clr` is pulsed, even after the feedback recovers.
- R10: During reset `hs_en`, `ls_en` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, asynchronous; 1 requests the high side |
| hs_gate_low | input | 1 | High-side gate feedback, 1 = gate below threshold (asynchronous) |
| ls_gate_low | input | 1 | Low-side gate feedback, 1 = gate below threshold (asynchronous) |
| vdd_code | input | 8 | Main supply level code |
| vboot_code | input | 8 | Bootstrap supply level code |
| vdd_trip_th | input | 8 | Main lockout engages when code is below this value |
| vdd_rel_th | input | 8 | Main lockout releases when code is at or above this value |
| vboot_trip_th | input | 8 | Bootstrap lockout engage threshold |
| vboot_rel_th | input | 8 | Bootstrap lockout release threshold |
| dead_cycles | input | 5 | Requested dead time in clock cycles, clamped to 9..20 |
| fb_timeout | input | 8 | Feedback timeout in cycles |
| fault_clr | input | 1 | Synchronous pulse that clears the sticky fault |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| fault | output | 1 | Sticky feedback-timeout fault |

## Verification
The assertions assume that the trip threshold of each lockout is below its release threshold. They also assume that the supply codes and `dead_cycles` change slowly compared with a switching transition. The bench keeps within these limits: it uses fixed thresholds of 100 and 150 and changes settings only while the outputs are in a steady state. Feedback is modelled as the inverse of the matching enable, so it stays high only when the bench deliberately holds it stuck for the timeout scenario.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_DEAD = 2'd1,
      ST_HS   = 2'd2,
      ST_LS   = 2'd3
   } hbd_state_e;

   typedef enum logic [1:0] {
      SIDE_NONE = 2'd0,
      SIDE_HS   = 2'd1,
      SIDE_LS   = 2'd2
   } hbd_side_e;

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hbd_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hbd_uvlo.sv
module hbd_uvlo #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] trip_th,
   input  logic [CODE_W-1:0] rel_th,
   output logic              lock
);

   if (CODE_W < 2) begin : g_bad_width
      $error("hbd_uvlo: CODE_W too small");
   end

   logic lock_q;
   logic below_trip;
   logic below_rel;

   assign below_trip = code < trip_th;
   assign below_rel  = code < rel_th;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q <= 1'b1;
      else if (lock_q) lock_q <= below_rel;
      else             lock_q <= below_trip;
   end

   assign lock = lock_q;

   assert_hold_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock && !below_trip) |=> !lock);

   assert_hold_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && below_rel) |=> lock);

endmodule

// File: rtl/hbd_seq.sv
module hbd_seq
   import hbd_pkg::*;
#(
   parameter int DT_W   = 5,
   parameter int TO_W   = 8,
   parameter int DT_MIN = 9,
   parameter int DT_MAX = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pwm_s,
   input  logic            hs_low_s,
   input  logic            ls_low_s,
   input  logic            uv_main,
   input  logic            uv_boot,
   input  logic [DT_W-1:0] dead_cycles,
   input  logic [TO_W-1:0] fb_timeout,
   input  logic            fault_clr,
   output logic            hs_en,
   output logic            ls_en,
   output logic            fault
);

   localparam logic [DT_W-1:0] DT_LO = DT_W'(DT_MIN);
   localparam logic [DT_W-1:0] DT_HI = DT_W'(DT_MAX);
   localparam logic [TO_W-1:0] TO_ONE = TO_W'(1);

   if (DT_MIN < 1 || DT_MIN > DT_MAX) begin : g_bad_range
      $error("hbd_seq: dead-time range is empty");
   end
   if (DT_MAX >= (1 << DT_W)) begin : g_bad_dtw
      $error("hbd_seq: DT_W too narrow for DT_MAX");
   end

   hbd_state_e      state_q, state_d;
   hbd_side_e       side_q, side_d;
   hbd_side_e       tgt;
   logic [DT_W-1:0] dt_eff, dt_cnt_q, dt_cnt_d;
   logic [TO_W-1:0] to_eff, to_cnt_q, to_cnt_d;
   logic            fault_q, fault_d;
   logic            out_low;
   logic            wait_fb;
   logic            timeout_hit;

   // dead time and timeout after clamping
   always_comb begin
      if (dead_cycles < DT_LO)      dt_eff = DT_LO;
      else if (dead_cycles > DT_HI) dt_eff = DT_HI;
      else                          dt_eff = dead_cycles;
      to_eff = (fb_timeout == '0) ? TO_ONE : fb_timeout;
   end

   // requested side
   always_comb begin
      tgt = SIDE_NONE;
      if (!uv_main && !fault_q) begin
         if (pwm_s) begin
            if (!uv_boot) tgt = SIDE_HS;
         end else begin
            tgt = SIDE_LS;
         end
      end
      // feedback of the gate that must be off before tgt turns on
      out_low = (tgt == SIDE_HS) ? ls_low_s : hs_low_s;
   end

   assign wait_fb     = (state_q == ST_WAIT) && (tgt != SIDE_NONE) && !out_low;
   assign timeout_hit = wait_fb && (to_cnt_q == to_eff - TO_ONE);

   always_comb begin
      state_d  = state_q;
      side_d   = side_q;
      dt_cnt_d = dt_cnt_q;
      unique case (state_q)
         ST_HS: if (tgt != SIDE_HS) state_d = ST_WAIT;
         ST_LS: if (tgt != SIDE_LS) state_d = ST_WAIT;
         ST_DEAD: begin
            if (tgt != side_q) begin
               state_d = ST_WAIT;
            end else if (dt_cnt_q == dt_eff - DT_W'(1)) begin
               state_d = (side_q == SIDE_HS) ? ST_HS : ST_LS;
            end else begin
               dt_cnt_d = dt_cnt_q + DT_W'(1);
            end
         end
         default: begin
            if (tgt != SIDE_NONE && out_low) begin
               state_d  = ST_DEAD;
               side_d   = tgt;
               dt_cnt_d = '0;
            end
         end
      endcase
      to_cnt_d = wait_fb ? to_cnt_q + TO_W'(1) : '0;
      if (timeout_hit)    fault_d = 1'b1;
      else if (fault_clr) fault_d = 1'b0;
      else                fault_d = fault_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_WAIT;
         side_q   <= SIDE_NONE;
         dt_cnt_q <= '0;
         to_cnt_q <= '0;
         fault_q  <= 1'b0;
      end else begin
         state_q  <= state_d;
         side_q   <= side_d;
         dt_cnt_q <= dt_cnt_d;
         to_cnt_q <= timeout_hit ? '0 : to_cnt_d;
         fault_q  <= fault_d;
      end
   end

   assign hs_en = (state_q == ST_HS);
   assign ls_en = (state_q == ST_LS);
   assign fault = fault_q;

   assert_hs_after_ls_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> ($past(!ls_en) && $past(!ls_en, 2)));

   assert_ls_after_hs_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en) |-> ($past(!hs_en) && $past(!hs_en, 2)));

   assert_dead_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEAD && tgt == side_q && dt_cnt_q < dt_eff - DT_W'(1))
      |=> (!hs_en && !ls_en));

   assert_main_uv_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      uv_main |=> (!hs_en && !ls_en));

   assert_boot_uv_hs_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      uv_boot |=> !hs_en);

   assert_fault_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!hs_en && !ls_en));

   assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !fault_clr) |=> fault);

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
   parameter int CODE_W      = 8,
   parameter int DT_W        = 5,
   parameter int TO_W        = 8,
   parameter int DT_MIN      = 9,
   parameter int DT_MAX      = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_in,
   input  logic              hs_gate_low,
   input  logic              ls_gate_low,
   input  logic [CODE_W-1:0] vdd_code,
   input  logic [CODE_W-1:0] vboot_code,
   input  logic [CODE_W-1:0] vdd_trip_th,
   input  logic [CODE_W-1:0] vdd_rel_th,
   input  logic [CODE_W-1:0] vboot_trip_th,
   input  logic [CODE_W-1:0] vboot_rel_th,
   input  logic [DT_W-1:0]   dead_cycles,
   input  logic [TO_W-1:0]   fb_timeout,
   input  logic              fault_clr,
   output logic              hs_en,
   output logic              ls_en,
   output logic              fault
);

   localparam int N_SUP = 2;

   logic [2:0]        raw_in, syn_out;
   logic [CODE_W-1:0] sup_code [N_SUP];
   logic [CODE_W-1:0] sup_trip [N_SUP];
   logic [CODE_W-1:0] sup_rel  [N_SUP];
   logic [N_SUP-1:0]  sup_lock;

   assign raw_in = {hs_gate_low, ls_gate_low, pwm_in};

   hbd_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_out)
   );

   assign sup_code[0] = vdd_code;
   assign sup_trip[0] = vdd_trip_th;
   assign sup_rel[0]  = vdd_rel_th;
   assign sup_code[1] = vboot_code;
   assign sup_trip[1] = vboot_trip_th;
   assign sup_rel[1]  = vboot_rel_th;

   for (genvar s = 0; s < N_SUP; s++) begin : g_uvlo
      hbd_uvlo #(.CODE_W(CODE_W)) u_uvlo (
         .clk     (clk),
         .rst_n   (rst_n),
         .code    (sup_code[s]),
         .trip_th (sup_trip[s]),
         .rel_th  (sup_rel[s]),
         .lock    (sup_lock[s])
      );
   end

   hbd_seq #(
      .DT_W   (DT_W),
      .TO_W   (TO_W),
      .DT_MIN (DT_MIN),
      .DT_MAX (DT_MAX)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwm_s       (syn_out[0]),
      .hs_low_s    (syn_out[2]),
      .ls_low_s    (syn_out[1]),
      .uv_main     (sup_lock[0]),
      .uv_boot     (sup_lock[1]),
      .dead_cycles (dead_cycles),
      .fb_timeout  (fb_timeout),
      .fault_clr   (fault_clr),
      .hs_en       (hs_en),
      .ls_en       (ls_en),
      .fault       (fault)
   );

   assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({hs_en, ls_en}) <= 1);

   assert_reset_quiet_R10: assert property (@(posedge clk)
      !rst_n |-> (!hs_en && !ls_en && !fault));

endmodule

// File: tb/hb_deadtime_ctrl_tb.sv
module hb_deadtime_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_in = 1'b0;
   logic       hs_stuck = 1'b0;
   logic       ls_stuck = 1'b0;
   logic [7:0] vdd_code = 8'd0;
   logic [7:0] vboot_code = 8'd0;
   logic [4:0] dead_cycles = 5'd12;
   logic [7:0] fb_timeout = 8'd40;
   logic       fault_clr = 1'b0;
   logic       hs_en, ls_en, fault;
   logic       hs_gate_low, ls_gate_low;

   int checks = 0;
   int errors = 0;
   int overlaps = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   // gate model: feedback follows the enable at once unless held stuck
   assign hs_gate_low = hs_stuck ? 1'b0 : !hs_en;
   assign ls_gate_low = ls_stuck ? 1'b0 : !ls_en;

   hb_deadtime_ctrl u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .pwm_in        (pwm_in),
      .hs_gate_low   (hs_gate_low),
      .ls_gate_low   (ls_gate_low),
      .vdd_code      (vdd_code),
      .vboot_code    (vboot_code),
      .vdd_trip_th   (8'd100),
      .vdd_rel_th    (8'd150),
      .vboot_trip_th (8'd100),
      .vboot_rel_th  (8'd150),
      .dead_cycles   (dead_cycles),
      .fb_timeout    (fb_timeout),
      .fault_clr     (fault_clr),
      .hs_en         (hs_en),
      .ls_en         (ls_en),
      .fault         (fault)
   );

   // R1 monitor on every cycle
   always @(negedge clk) if (rst_n && hs_en && ls_en) overlaps++;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic int clampdt(input int d);
      return (d < 9) ? 9 : ((d > 20) ? 20 : d);
   endfunction

   // R10, R5: reset state and lockout active out of reset
   task automatic t_reset();
      cyc(3);
      check("R10 hs_en in reset", int'(hs_en), 0);
      check("R10 ls_en in reset", int'(ls_en), 0);
      check("R10 fault in reset", int'(fault), 0);
      rst_n = 1'b1;
      cyc(40);
      check("R5 both low while locked", int'(hs_en | ls_en), 0);
      vdd_code = 8'd200;
      vboot_code = 8'd200;
      cyc(40);
      check("R5 ls on after release", int'(ls_en), 1);
   endtask

   // R2/R3/R4: gap of both-low cycles around a transition
   task automatic t_gap(input bit rise, input int dt, input string req);
      int gap = 0;
      bit seen_in = 1'b0;
      dead_cycles = 5'(dt);
      cyc(2);
      pwm_in = rise;
      for (int i = 0; i < 100 && !seen_in; i++) begin
         @(negedge clk);
         if (rise ? hs_en : ls_en) seen_in = 1'b1;
         else if (!hs_en && !ls_en) gap++;
      end
      check({req, " incoming on"}, int'(seen_in), 1);
      check({req, " gap"}, gap, 3 + clampdt(dt));
      cyc(5);
   endtask

   // R6: bootstrap lockout blocks only the high side
   task automatic t_boot();
      vboot_code = 8'd50;
      cyc(5);
      pwm_in = 1'b1;
      cyc(40);
      check("R6 hs held off", int'(hs_en), 0);
      pwm_in = 1'b0;
      cyc(40);
      check("R6 ls follows pwm", int'(ls_en), 1);
      vboot_code = 8'd120;
      pwm_in = 1'b1;
      cyc(40);
      check("R7 boot stays locked mid band", int'(hs_en), 0);
      vboot_code = 8'd200;
      cyc(40);
      check("R6 hs after boot release", int'(hs_en), 1);
      pwm_in = 1'b0;
      cyc(40);
   endtask

   // R7, R5: main supply hysteresis
   task automatic t_hyst();
      vdd_code = 8'd120;
      cyc(20);
      check("R7 mid band keeps release", int'(ls_en), 1);
      vdd_code = 8'd90;
      cyc(5);
      check("R5 main lock drops ls", int'(ls_en | hs_en), 0);
      vdd_code = 8'd120;
      cyc(40);
      check("R7 mid band keeps lock", int'(ls_en | hs_en), 0);
      vdd_code = 8'd160;
      cyc(40);
      check("R7 release above threshold", int'(ls_en), 1);
   endtask

   // R8: command reversal during a dead-time wait
   task automatic t_reverse();
      bit hs_seen = 1'b0;
      dead_cycles = 5'd20;
      cyc(2);
      pwm_in = 1'b1;
      cyc(9);
      check("R8 in dead wait", int'(hs_en | ls_en), 0);
      pwm_in = 1'b0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (hs_en) hs_seen = 1'b1;
      end
      check("R8 hs never on", int'(hs_seen), 0);
      check("R8 ls restored", int'(ls_en), 1);
   endtask

   // R9: feedback timeout fault
   task automatic t_timeout();
      fb_timeout = 8'd30;
      ls_stuck = 1'b1;
      cyc(2);
      pwm_in = 1'b1;
      cyc(60);
      check("R9 fault set", int'(fault), 1);
      check("R9 outputs off", int'(hs_en | ls_en), 0);
      pwm_in = 1'b0;
      ls_stuck = 1'b0;
      cyc(40);
      check("R9 fault sticky", int'(fault), 1);
      check("R9 ls held off", int'(ls_en), 0);
      fault_clr = 1'b1;
      cyc(1);
      fault_clr = 1'b0;
      cyc(40);
      check("R9 fault cleared", int'(fault), 0);
      check("R9 ls resumes", int'(ls_en), 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_gap(1'b1, 12, "R2 rise dt12");
      t_gap(1'b0, 12, "R3 fall dt12");
      t_gap(1'b1, 3,  "R4 rise clamp low");
      t_gap(1'b0, 25, "R4 fall clamp high");
      t_gap(1'b1, 20, "R4 rise max");
      t_gap(1'b0, 9,  "R3 fall min");
      t_boot();
      t_hyst();
      t_reverse();
      t_timeout();
      check("R1 no overlap", overlaps, 0);
      finish_run();
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

endmodule